// File: doc/BRIEF.md
# Bit-Serial Neuron with Early Negative Cut-Off

This block computes one neural-network output neuron: the dot product of a vector of unsigned activations with a vector of signed weights, followed by a ReLU that clamps negative results to zero. The dot product is evaluated one weight bit-plane per clock cycle. The walk starts at the most significant plane and moves toward the least significant one.

On an accepted start, each weight is re-coded so that its top bit carries a positive place value and every lower bit carries a negative one. The first plane can therefore only raise the running sum, and every later plane can only lower it. The first time the running sum falls below zero, the final result is certain to be negative. At that point the block stops, reports a zero output, and raises a flag that marks the skipped cycles.

The caller pulses `start` with both vectors present, then waits for `done`. While a computation runs, further start requests have no effect. The result stays on `y` until the next completion.

Top module: `relu_bitserial_neuron`

## Requirements
- R1: After reset, `done`, `early_stop` and `bad_weight` are 0 and `y` is 0, including when reset interrupts a computation in progress.
- R2: For 16 lanes, where lane i uses bits [8i+7:8i] of `act_in` (unsigned) and of `wgt_in` (two's complement, range -127..127), `y` equals max(0, sum of act_i * w_i).
- R3: When no early cut-off happens, `done` rises on the 8th clock edge after the edge that accepts `start`, with `early_stop` low. This includes results that first turn negative on the lowest plane.
- R4: Planes are taken from bit 7 down to bit 0. Each weight is re-coded as b7*128 minus the sum of bi*2^i over i = 0..6. A non-negative nonzero w sets b7=1 with a low field of 128-w. Zero and negative w set b7=0 with a low field of -w. If the running sum first drops strictly below zero after plane p < 7, `done` rises on edge 8-p after the accepting edge, with `y`=0 and `early_stop`=1. A running sum of exactly zero does not stop the walk.
- R5: `early_stop` is high only in a cycle where `done` is high.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: A `start` that arrives while a computation is running is ignored. The running result, its latency and its operands are unchanged.
- R8: `y` changes only in a cycle where `done` is high. It holds its value across idle cycles even when `act_in` and `wgt_in` change.
- R9: If any weight equals -128 when `start` is accepted, no walk takes place. `done` rises on the first edge after the accepting edge, with `bad_weight`=1, `y`=0 and `early_stop`=0. A weight of -127 is accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new neuron evaluation; sampled only when idle |
| act_in | input | 128 | Sixteen unsigned 8-bit activations, lane 0 in the low byte |
| wgt_in | input | 128 | Sixteen two's-complement 8-bit weights, lane 0 in the low byte |
| done | output | 1 | One-cycle completion pulse |
| y | output | 19 | ReLU output of the neuron, held between completions |
| early_stop | output | 1 | Valid with done: the walk ended before the lowest plane |
| bad_weight | output | 1 | Valid with done: an unrepresentable weight was presented |

## Verification
The latency properties count edges from the first edge where `start` meets an idle block. They therefore assume that reset has been applied before any request and that `start` is a synchronous level. The bench drives `start` and the operand vectors only on falling edges and releases `start` after the accepting edge, except where it deliberately holds a request against a busy block. The properties take every 8-bit weight pattern as legal input, because the one value the re-coding cannot represent is routed to the rejection path. The bench therefore covers both the -128 and the -127 edge values.

// File: rtl/relu_bs_pkg.sv
package relu_bs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_REJ  = 2'd2
   } nrn_state_t;

endpackage

// File: rtl/wgt_inv_enc.sv
module wgt_inv_enc #(
   parameter int W = 8
) (
   input  logic [W-1:0] w,
   output logic [W-1:0] code,
   output logic         ok
);

   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   logic [W-2:0] low_field;

   always_comb begin
      ok = (w != MOST_NEG);
      if (!w[W-1] && (w != '0)) begin
         // positive top plane, lower planes subtract the remainder
         low_field = (W-1)'(MOST_NEG - w);
         code      = {1'b1, low_field};
      end else begin
         // zero or negative: only the subtracting planes are used
         low_field = (W-1)'('0 - w);
         code      = {1'b0, low_field};
      end
   end

endmodule

// File: rtl/plane_dot.sv
module plane_dot #(
   parameter int N = 16,
   parameter int A = 8,
   parameter int S = 13
) (
   input  logic [N*A-1:0] acts,
   input  logic [N-1:0]   sel,
   output logic [S-1:0]   sum
);

   logic [N-1:0][A-1:0] masked;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_lane
         assign masked[gi] = sel[gi] ? acts[gi*A +: A] : '0;
      end
   endgenerate

   always_comb begin
      sum = '0;
      for (int i = 0; i < N; i++) begin
         sum = sum + S'(masked[i]);
      end
   end

endmodule

// File: rtl/relu_bitserial_neuron.sv
module relu_bitserial_neuron
   import relu_bs_pkg::*;
#(
   parameter int N_IN       = 16,
   parameter int ACT_W      = 8,
   parameter int WGT_W      = 8,
   parameter int ACC_W      = 20,
   parameter bit EARLY_STOP = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [N_IN*ACT_W-1:0]  act_in,
   input  logic [N_IN*WGT_W-1:0]  wgt_in,
   output logic                   done,
   output logic [ACC_W-2:0]       y,
   output logic                   early_stop,
   output logic                   bad_weight
);

   localparam int PS_W   = ACT_W + $clog2(N_IN + 1);
   localparam int PIDX_W = (WGT_W > 2) ? $clog2(WGT_W) : 1;
   localparam logic [PIDX_W-1:0] TOP_PLANE = PIDX_W'(WGT_W - 1);

   generate
      if (ACC_W < ACT_W + WGT_W + $clog2(N_IN)) begin : g_chk_acc
         $error("ACC_W too narrow for the largest neuron sum");
      end
      if (WGT_W < 2) begin : g_chk_wgt
         $error("WGT_W must be at least 2");
      end
      if (N_IN < 1) begin : g_chk_n
         $error("N_IN must be at least 1");
      end
      if (ACC_W <= PS_W) begin : g_chk_ps
         $error("ACC_W must exceed the plane sum width");
      end
   endgenerate

   nrn_state_t                  state_q;
   logic [PIDX_W-1:0]           pidx_q;
   logic signed [ACC_W-1:0]     psum_q;
   logic signed [ACC_W-1:0]     psum_nxt;
   logic [ACC_W-1:0]            term;
   logic [N_IN-1:0][WGT_W-1:0]  code_d;
   logic [N_IN-1:0][WGT_W-1:0]  code_q;
   logic [N_IN-1:0]             ok_d;
   logic [N_IN*ACT_W-1:0]       act_q;
   logic [N_IN-1:0]             plane_bits;
   logic [PS_W-1:0]             plane_sum;
   logic                        all_ok;
   logic                        neg;
   logic                        finish;
   logic                        busy;

   genvar gi;
   generate
      for (gi = 0; gi < N_IN; gi++) begin : g_enc
         wgt_inv_enc #(.W(WGT_W)) u_enc (
            .w    (wgt_in[gi*WGT_W +: WGT_W]),
            .code (code_d[gi]),
            .ok   (ok_d[gi])
         );
         assign plane_bits[gi] = code_q[gi][pidx_q];
      end
   endgenerate

   plane_dot #(.N(N_IN), .A(ACT_W), .S(PS_W)) u_dot (
      .acts (act_q),
      .sel  (plane_bits),
      .sum  (plane_sum)
   );

   assign all_ok = &ok_d;
   assign busy   = (state_q != ST_IDLE);
   assign term   = {{(ACC_W-PS_W){1'b0}}, plane_sum} << pidx_q;

   always_comb begin
      if (pidx_q == TOP_PLANE) begin
         psum_nxt = psum_q + signed'(term);
      end else begin
         psum_nxt = psum_q - signed'(term);
      end
   end

   assign neg = psum_nxt[ACC_W-1];

   generate
      if (EARLY_STOP) begin : g_cut
         assign finish = (pidx_q == '0) || neg;
      end else begin : g_full
         assign finish = (pidx_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pidx_q     <= '0;
         psum_q     <= '0;
         code_q     <= '0;
         act_q      <= '0;
         done       <= 1'b0;
         y          <= '0;
         early_stop <= 1'b0;
         bad_weight <= 1'b0;
      end else begin
         done       <= 1'b0;
         early_stop <= 1'b0;
         bad_weight <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (all_ok) begin
                     code_q  <= code_d;
                     act_q   <= act_in;
                     psum_q  <= '0;
                     pidx_q  <= TOP_PLANE;
                     state_q <= ST_RUN;
                  end else begin
                     state_q <= ST_REJ;
                  end
               end
            end
            ST_RUN: begin
               psum_q <= psum_nxt;
               if (finish) begin
                  state_q    <= ST_IDLE;
                  done       <= 1'b1;
                  early_stop <= (pidx_q != '0);
                  y          <= neg ? '0 : psum_nxt[ACC_W-2:0];
               end else begin
                  pidx_q <= pidx_q - 1'b1;
               end
            end
            ST_REJ: begin
               state_q    <= ST_IDLE;
               done       <= 1'b1;
               bad_weight <= 1'b1;
               y          <= '0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/relu_bs_checker.sv
module relu_bs_checker #(
   parameter int WGT_W = 8,
   parameter int OUT_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             early_stop,
   input logic             bad_weight,
   input logic [OUT_W-1:0] y
);

   logic [7:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
      end else if (start && !busy) begin
         edge_cnt <= '0;
      end else if (busy) begin
         edge_cnt <= edge_cnt + 8'd1;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                 // R6
   AST_EARLY_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      early_stop |-> done);                                            // R5
   AST_BAD_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      bad_weight |-> (done && !early_stop));                           // R9
   AST_EARLY_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && early_stop) |-> (y == '0));                             // R4
   AST_FULL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !early_stop && !bad_weight) |-> (edge_cnt == 8'(WGT_W))); // R3
   AST_EARLY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && early_stop) |-> (edge_cnt >= 8'd2 && edge_cnt < 8'(WGT_W))); // R4
   AST_REJECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bad_weight) |-> (edge_cnt == 8'd1));                    // R9
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(y));                                           // R8
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));                             // R7

endmodule

bind relu_bitserial_neuron relu_bs_checker #(
   .WGT_W (WGT_W),
   .OUT_W (ACC_W - 1)
) u_relu_bs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .early_stop (early_stop),
   .bad_weight (bad_weight),
   .y          (y)
);

// File: tb/test_relu_bitserial_neuron.sv
module test_relu_bitserial_neuron;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] act_in = '0;
   logic [127:0] wgt_in = '0;
   logic         done;
   logic [18:0]  y;
   logic         early_stop;
   logic         bad_weight;

   int n_chk  = 0;
   int n_fail = 0;

   always #10ns clk = ~clk;   // 50 MHz

   relu_bitserial_neuron i_relu_bitserial_neuron (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .act_in     (act_in),
      .wgt_in     (wgt_in),
      .done       (done),
      .y          (y),
      .early_stop (early_stop),
      .bad_weight (bad_weight)
   );

   typedef struct packed {
      logic [127:0] act;
      logic [127:0] wgt;
      logic [19:0]  ey;
      logic [7:0]   elat;
      logic         eearly;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      // single positive lane: 10*3
      '{ {120'd0, 8'd10}, {120'd0, 8'd3}, 20'd30, 8'd8, 1'b0 },
      // 10*-3: negative after plane 1
      '{ {120'd0, 8'd10}, {120'd0, 8'hFD}, 20'd0, 8'd7, 1'b1 },
      // 1*-64: negative after plane 6
      '{ {120'd0, 8'd1}, {120'd0, 8'hC0}, 20'd0, 8'd2, 1'b1 },
      // all zero
      '{ 128'd0, 128'd0, 20'd0, 8'd8, 1'b0 },
      // 1*-1: negative only on the lowest plane
      '{ {120'd0, 8'd1}, {120'd0, 8'hFF}, 20'd0, 8'd8, 1'b0 },
      // 100*127 + 50*-2
      '{ {112'd0, 8'd50, 8'd100}, {112'd0, 8'hFE, 8'd127}, 20'd12600, 8'd8, 1'b0 },
      // all lanes 255*127
      '{ {16{8'd255}}, {16{8'd127}}, 20'd518160, 8'd8, 1'b0 },
      // zero weight lane plus 3*5
      '{ {112'd0, 8'd3, 8'd200}, {112'd0, 8'd5, 8'd0}, 20'd15, 8'd8, 1'b0 },
      // 10*10 + 10*-20: sum hits exactly zero at plane 4, negative at plane 2
      '{ {112'd0, 8'd10, 8'd10}, {112'd0, 8'hEC, 8'd10}, 20'd0, 8'd6, 1'b1 }
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // inject >= 0: raise start with other operands while busy, in that cycle
   task automatic run(input logic [127:0] a, input logic [127:0] w,
                      input logic [19:0] ey, input int elat, input logic eearly,
                      input logic ebad, input int inject, input string req);
      int lat;
      @(negedge clk);
      act_in = a;
      wgt_in = w;
      start  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat   = 0;
      while (!done && lat < 20) begin
         if (lat == inject) begin
            start  = 1'b1;
            act_in = {16{8'd255}};
            wgt_in = {16{8'd127}};
         end else if (lat == inject + 1) begin
            start = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk({req, " latency"}, lat, elat);
      chk({req, " y"}, 32'(y), 32'(ey));
      chk({req, " early_stop"}, 32'(early_stop), 32'(eearly));
      chk({req, " bad_weight"}, 32'(bad_weight), 32'(ebad));
      @(negedge clk);
      chk("R6 done single cycle", 32'(done), 0);
   endtask

   initial begin
      #(20ns * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 done", 32'(done), 0);
      chk("R1 y", 32'(y), 0);
      chk("R1 flags", {30'd0, early_stop, bad_weight}, 0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5
      for (int k = 0; k < NV; k++) begin
         run(TBL[k].act, TBL[k].wgt, TBL[k].ey, int'(TBL[k].elat), TBL[k].eearly,
             1'b0, -1, TBL[k].eearly ? "R4" : "R2/R3");
      end

      // R7: start while busy has no effect
      run({120'd0, 8'd10}, {120'd0, 8'd3}, 20'd30, 8, 1'b0, 1'b0, 3, "R7");

      // R8: output holds while idle and inputs move
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         act_in = {16{8'(k * 37)}};
         wgt_in = {16{8'(k * 11)}};
         chk("R8 y hold", 32'(y), 30);
         chk("R8 no done", 32'(done), 0);
      end

      // R9: -128 in lane 5 rejected, -127 accepted
      run({128'd0} | {120'd0, 8'd9}, {80'd0, 8'h80, 40'd0}, 20'd0, 1, 1'b0, 1'b1, -1, "R9 reject");
      run({120'd0, 8'd1}, {120'd0, 8'h81}, 20'd0, 2, 1'b1, 1'b0, -1, "R9 minus127");

      // R1: reset in the middle of a computation
      run({120'd0, 8'd100}, {120'd0, 8'd100}, 20'd10000, 8, 1'b0, 1'b0, -1, "R2 pre-reset");
      @(negedge clk);
      act_in = {120'd0, 8'd20};
      wgt_in = {120'd0, 8'd20};
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run y", 32'(y), 0);
      chk("R1 mid-run done", 32'(done), 0);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      chk("R1 no stale done", 32'(done), 0);
      chk("R1 y after reset", 32'(y), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule